// File: doc/BRIEF.md
# Serial Flash Command Transfer Engine

This block runs one short command frame at a time against up to four SPI serial flash devices, each with its own chip select. Software fills a 32-bit transmit word with an opcode and up to three address bytes. It then writes a control word that carries the transmit and receive byte counts, the target device and a start bit. The engine drives SCK in SPI mode 0 from the bus clock divided by a programmable prescaler. It shifts the transmit bytes out on MOSI, captures the reply from MISO into a receive word, and then raises a sticky finished flag. That flag can also drive an interrupt line.

A frame is accepted only while the software-mode bit is set and no earlier frame is still in flight. After every frame the chip select stays high for a programmable number of SCK periods, and the finished flag rises only once that spacing has elapsed. A start aimed at a disabled device, or one with no transmit bytes, finishes at once without touching the serial pins.

Top module: `sflash_xfer_engine`

## Requirements
- R1: After reset, all five registers read 0, every chip select is high, SCK is low and the interrupt is low.
- R2: Registers are addressed by word index: 0 mode word, 1 command word, 2 status, 3 transmit word, 4 receive word. Indices 5 to 7 read 0 and the receive word ignores writes. The mode word keeps only bits [3:0] (per-device enable), [6:5] (deselect time), [11:8] (prescaler) and [28] (software mode). The command word keeps only bits [2:0] (transmit count), [6:4] (receive count), [8] (interrupt enable) and [13:12] (device). Command bit 7 (start) always reads 0.
- R3: A command write with bit 7 set launches a frame only when mode bit 28 is 1. Otherwise no chip select falls, SCK stays idle and the finished flag stays 0.
- R4: SCK idles low. MOSI changes only while SCK is low. Transmit-word bits [7:0] go out first, then [15:8], [23:16] and [31:24], each byte most significant bit first.
- R5: MISO is sampled on SCK rising edges after the transmit bytes. Reply byte k lands in receive-word bits [8k+7:8k], and the bytes above the received count read 0.
- R6: One SCK period lasts P bus cycles, where P is the prescaler, or 2 when the prescaler is below 2. A frame has exactly 8 x (transmit count + receive count) rising edges.
- R7: Only the chip select of the device named in command bits [13:12] goes low during a frame, and it stays low without a break from the first to the last SCK edge.
- R8: Count values 5 to 7 act as 4. A receive count of 0 gives a transmit-only frame.
- R9: A start with transmit count 0, or aimed at a device whose enable bit is 0, sets the finished flag on the write edge with no chip-select or SCK activity.
- R10: Status bit 8 (finished) stays set until software writes the status word with bit 8 at 0. Writing 1 there has no effect.
- R11: The interrupt output is high exactly while the finished flag and command bit 8 are both 1.
- R12: After the last SCK falling edge the chip select is high for exactly P x (deselect time + 1) bus cycles before the finished flag rises. A start issued while a frame or its deselect gap is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | 4 | Active-low chip selects, one per device |
| irq | output | 1 | Finished interrupt |

## Verification
The bench sweeps prescalers on both sides of the minimum and every transmit and receive count from the smallest up to the clamped values, rotating the target device and the deselect time. A design with a wrong byte order would put reply bytes in the wrong lanes or send the address before the opcode. A miscounted divider would show up as a wrong SCK period or a wrong number of edges. A design that raised the flag when the chip select rose would fail the measured deselect gap. Separate cases start frames with software mode off, with a disabled device or zero count, and during a running frame. Wrongly accepting any of these would drop a chip select or emit SCK edges. Other cases write a 1 to the status flag and disable the interrupt, which catches a flag that clears too easily and an interrupt that ignores its enable.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  // register word indices
  localparam logic [2:0] IDX_MODE = 3'd0;
  localparam logic [2:0] IDX_CMD  = 3'd1;
  localparam logic [2:0] IDX_STAT = 3'd2;
  localparam logic [2:0] IDX_TXW  = 3'd3;
  localparam logic [2:0] IDX_RXW  = 3'd4;

  // field positions
  localparam int MODE_SW_BIT  = 28;
  localparam int CMD_GO_BIT   = 7;
  localparam int CMD_IE_BIT   = 8;
  localparam int CMD_DEV_LSB  = 12;
  localparam int STAT_FIN_BIT = 8;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_GAP  = 2'd2
  } seq_state_e;

  function automatic logic [2:0] clamp_cnt(input logic [2:0] n, input int lim);
    return (int'(n) > lim) ? 3'(lim) : n;
  endfunction
endpackage

// File: rtl/sfx_sckgen.sv
module sfx_sckgen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] presc,
  output logic       sck_rise,
  output logic       sck_fall
);
  logic [3:0] cnt_q, cnt_d;
  logic [3:0] p_eff, lo_len;

  always_comb begin
    p_eff  = (presc < 4'd2) ? 4'd2 : presc;
    lo_len = p_eff - (p_eff >> 1);
    if (!run)                      cnt_d = '0;
    else if (cnt_q == p_eff - 4'd1) cnt_d = '0;
    else                           cnt_d = cnt_q + 4'd1;
    sck_rise = run && (cnt_q == lo_len - 4'd1);
    sck_fall = run && (cnt_q == p_eff - 4'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sfx_regs.sv
module sfx_regs
  import sfx_pkg::*;
#(
  parameter  int NBANK  = 4,
  localparam int BANK_W = $clog2(NBANK),
  localparam int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        idx,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [DW-1:0]     rxw,
  input  logic              busy,
  input  logic              done_set,
  output logic              start,
  output logic [2:0]        go_tx,
  output logic [2:0]        go_rx,
  output logic [BANK_W-1:0] go_dev,
  output logic [DW-1:0]     txw,
  output logic [NBANK-1:0]  dev_en,
  output logic [1:0]        dsel,
  output logic [3:0]        presc,
  output logic              done,
  output logic              irq
);
  logic [NBANK-1:0]  en_q, en_d;
  logic [1:0]        dsel_q, dsel_d;
  logic [3:0]        presc_q, presc_d;
  logic              sw_q, sw_d;
  logic [2:0]        tx_q, tx_d, rx_q, rx_d;
  logic              ie_q, ie_d;
  logic [BANK_W-1:0] dev_q, dev_d;
  logic [DW-1:0]     txw_q, txw_d;
  logic              done_q, done_d;
  logic              wr_mode, wr_cmd, wr_stat, wr_txw;

  always_comb begin
    wr_mode = wr && (idx == IDX_MODE);
    wr_cmd  = wr && (idx == IDX_CMD);
    wr_stat = wr && (idx == IDX_STAT);
    wr_txw  = wr && (idx == IDX_TXW);

    en_d = en_q; dsel_d = dsel_q; presc_d = presc_q; sw_d = sw_q;
    tx_d = tx_q; rx_d = rx_q; ie_d = ie_q; dev_d = dev_q;
    txw_d = txw_q; done_d = done_q;

    if (wr_mode) begin
      en_d    = wdata[NBANK-1:0];
      dsel_d  = wdata[6:5];
      presc_d = wdata[11:8];
      sw_d    = wdata[MODE_SW_BIT];
    end
    if (wr_cmd) begin
      tx_d  = wdata[2:0];
      rx_d  = wdata[6:4];
      ie_d  = wdata[CMD_IE_BIT];
      dev_d = wdata[CMD_DEV_LSB +: BANK_W];
    end
    if (wr_txw) txw_d = wdata[DW-1:0];
    if (wr_stat && !wdata[STAT_FIN_BIT]) done_d = 1'b0;
    if (done_set) done_d = 1'b1;

    // a launch takes its fields straight from the write data
    start  = wr_cmd && wdata[CMD_GO_BIT] && sw_q && !busy;
    go_tx  = wdata[2:0];
    go_rx  = wdata[6:4];
    go_dev = wdata[CMD_DEV_LSB +: BANK_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; dsel_q <= '0; presc_q <= '0; sw_q <= 1'b0;
      tx_q <= '0; rx_q <= '0; ie_q <= 1'b0; dev_q <= '0;
      txw_q <= '0; done_q <= 1'b0;
    end else begin
      en_q <= en_d; dsel_q <= dsel_d; presc_q <= presc_d; sw_q <= sw_d;
      tx_q <= tx_d; rx_q <= rx_d; ie_q <= ie_d; dev_q <= dev_d;
      txw_q <= txw_d; done_q <= done_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_MODE: begin
        rdata[NBANK-1:0]   = en_q;
        rdata[6:5]         = dsel_q;
        rdata[11:8]        = presc_q;
        rdata[MODE_SW_BIT] = sw_q;
      end
      IDX_CMD: begin
        rdata[2:0]                     = tx_q;
        rdata[6:4]                     = rx_q;
        rdata[CMD_IE_BIT]              = ie_q;
        rdata[CMD_DEV_LSB +: BANK_W]   = dev_q;
      end
      IDX_STAT: rdata[STAT_FIN_BIT] = done_q;
      IDX_TXW:  rdata = 32'(txw_q);
      IDX_RXW:  rdata = 32'(rxw);
      default:  rdata = '0;
    endcase
  end

  assign txw    = txw_q;
  assign dev_en = en_q;
  assign dsel   = dsel_q;
  assign presc  = presc_q;
  assign done   = done_q;
  assign irq    = done_q & ie_q;
endmodule

// File: rtl/sfx_seq.sv
module sfx_seq
  import sfx_pkg::*;
#(
  parameter  int NBANK     = 4,
  parameter  int MAX_BYTES = 4,
  localparam int BANK_W    = $clog2(NBANK),
  localparam int DW        = 8 * MAX_BYTES,
  localparam int IDX_W     = $clog2(DW),
  localparam int SLOT_W    = $clog2(MAX_BYTES),
  localparam int BIT_W     = $clog2(16 * MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        go_tx,
  input  logic [2:0]        go_rx,
  input  logic [BANK_W-1:0] go_dev,
  input  logic [DW-1:0]     txw,
  input  logic [NBANK-1:0]  dev_en,
  input  logic [1:0]        dsel,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [NBANK-1:0]  cs_n,
  output logic [DW-1:0]     rxw,
  output logic              busy,
  output logic              done_set
);
  seq_state_e        st_q, st_d;
  logic [BIT_W-1:0]  bit_q, bit_d, txb_q, txb_d, tot_q, tot_d;
  logic [BIT_W-1:0]  nb, rx_off;
  logic [BANK_W-1:0] dev_q, dev_d;
  logic [DW-1:0]     txw_q, txw_d, rxw_q, rxw_d;
  logic [7:0]        rxb_q, rxb_d;
  logic [1:0]        gap_q, gap_d;
  logic              sck_q, sck_d, mosi_q, mosi_d, act_q, act_d;
  logic [2:0]        tx_e, rx_e;

  always_comb begin
    st_d = st_q; bit_d = bit_q; txb_d = txb_q; tot_d = tot_q; dev_d = dev_q;
    txw_d = txw_q; rxw_d = rxw_q; rxb_d = rxb_q; gap_d = gap_q;
    sck_d = sck_q; mosi_d = mosi_q; act_d = act_q; done_set = 1'b0;
    tx_e   = clamp_cnt(go_tx, MAX_BYTES);
    rx_e   = clamp_cnt(go_rx, MAX_BYTES);
    nb     = bit_q + BIT_W'(1);
    rx_off = bit_q - txb_q;

    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          if ((tx_e == 3'd0) || !dev_en[go_dev]) begin
            done_set = 1'b1;
          end else begin
            st_d   = SQ_RUN;
            bit_d  = '0;
            txb_d  = BIT_W'(tx_e) << 3;
            tot_d  = (BIT_W'(tx_e) + BIT_W'(rx_e)) << 3;
            dev_d  = go_dev;
            txw_d  = txw;
            rxw_d  = '0;
            mosi_d = txw[7];
            act_d  = 1'b1;
          end
        end
      end
      SQ_RUN: begin
        if (sck_rise) begin
          sck_d = 1'b1;
          if (bit_q >= txb_q) begin
            rxb_d = {rxb_q[6:0], miso};
            if (&bit_q[2:0])
              rxw_d[{rx_off[SLOT_W+2:3], 3'b000} +: 8] = {rxb_q[6:0], miso};
          end
        end
        if (sck_fall) begin
          sck_d = 1'b0;
          bit_d = nb;
          if (nb == tot_q) begin
            st_d   = SQ_GAP;
            act_d  = 1'b0;
            mosi_d = 1'b0;
            gap_d  = '0;
          end else if (nb < txb_q) begin
            mosi_d = txw_q[{nb[IDX_W-1:3], ~nb[2:0]}];
          end else begin
            mosi_d = 1'b0;
          end
        end
      end
      SQ_GAP: begin
        if (sck_fall) begin
          if (gap_q == dsel) begin
            st_d     = SQ_IDLE;
            done_set = 1'b1;
          end else begin
            gap_d = gap_q + 2'd1;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; bit_q <= '0; txb_q <= '0; tot_q <= '0; dev_q <= '0;
      txw_q <= '0; rxw_q <= '0; rxb_q <= '0; gap_q <= '0;
      sck_q <= 1'b0; mosi_q <= 1'b0; act_q <= 1'b0;
    end else begin
      st_q <= st_d; bit_q <= bit_d; txb_q <= txb_d; tot_q <= tot_d; dev_q <= dev_d;
      txw_q <= txw_d; rxw_q <= rxw_d; rxb_q <= rxb_d; gap_q <= gap_d;
      sck_q <= sck_d; mosi_q <= mosi_d; act_q <= act_d;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_cs
    assign cs_n[b] = ~(act_q && (dev_q == BANK_W'(b)));
  end

  assign sck  = sck_q;
  assign mosi = mosi_q;
  assign rxw  = rxw_q;
  assign busy = (st_q != SQ_IDLE);
endmodule

// File: rtl/sflash_xfer_engine.sv
module sflash_xfer_engine #(
  parameter int NBANK     = 4,
  parameter int MAX_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_idx,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [NBANK-1:0] cs_n,
  output logic             irq
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int DW     = 8 * MAX_BYTES;

  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic              start, busy, done_set, done_flag;
  logic [2:0]        go_tx, go_rx;
  logic [BANK_W-1:0] go_dev;
  logic [DW-1:0]     txw, rxw;
  logic [NBANK-1:0]  dev_en;
  logic [1:0]        dsel;
  logic [3:0]        presc;
  logic              sck_rise, sck_fall;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  sfx_regs #(.NBANK(NBANK)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
    .rdata(reg_rdata), .rxw(rxw), .busy(busy), .done_set(done_set),
    .start(start), .go_tx(go_tx), .go_rx(go_rx), .go_dev(go_dev), .txw(txw),
    .dev_en(dev_en), .dsel(dsel), .presc(presc), .done(done_flag), .irq(irq)
  );

  sfx_sckgen u_sckgen (
    .clk(clk), .rst_n(rst_i_n), .run(busy), .presc(presc),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  sfx_seq #(.NBANK(NBANK), .MAX_BYTES(MAX_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start), .go_tx(go_tx), .go_rx(go_rx),
    .go_dev(go_dev), .txw(txw), .dev_en(dev_en), .dsel(dsel),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .miso(miso),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .rxw(rxw), .busy(busy), .done_set(done_set)
  );
endmodule

// File: rtl/sflash_xfer_engine_chk.sv
module sflash_xfer_engine_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck,
  input logic             mosi,
  input logic [NBANK-1:0] cs_n,
  input logic             irq,
  input logic             done,
  input logic             reg_wr,
  input logic [2:0]       reg_idx,
  input logic [31:0]      reg_wdata
);
  // R7: never more than one device selected
  a_r7_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R6: SCK stays low while no device is selected
  a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sck);

  // R4: MOSI is settled when SCK rises
  a_r4_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));

  // R12: the finished flag rises only with every chip select high
  a_r12_done_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (&cs_n));

  // R10: the flag holds unless a clearing status write occurs
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(reg_wr && reg_idx == 3'd2 && !reg_wdata[8])) |=> done);

  // R11: the interrupt needs the finished flag
  a_r11_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done);
endmodule

bind sflash_xfer_engine sflash_xfer_engine_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n), .irq(irq),
  .done(done_flag), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata)
);

// File: tb/sflash_xfer_engine_bench.sv
module sflash_xfer_engine_bench;
  logic        clk, rst_n, reg_wr, miso;
  logic [2:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sck, mosi, irq;
  logic [3:0]  cs_n;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  // monitor state
  int seed = 0;
  int edges, bitpos, bad_per, cs_falls, last_rise, cs_rise_cyc, irq_rise_cyc;
  bit have_rise, irq_seen;
  logic [63:0] mosi_log;
  logic [3:0]  low_mask;
  logic        sck_m, irq_m;
  logic [3:0]  cs_m;
  int          exp_p;

  sflash_xfer_engine u_sflash_xfer_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 190000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [7:0] resp_byte(input int m);
    return 8'((seed * 7 + m * 59 + 1) & 255);
  endfunction

  function automatic logic resp_bit(input int j);
    logic [7:0] b;
    b = resp_byte(j / 8);
    return b[7 - (j % 8)];
  endfunction

  function automatic int clampc(input int n);
    return (n > 4) ? 4 : n;
  endfunction

  // flash model, mode 0
  always @(posedge sck) begin
    edges = edges + 1;
    mosi_log = {mosi_log[62:0], mosi};
  end
  always @(negedge sck) begin
    bitpos = bitpos + 1;
    miso = resp_bit(bitpos);
  end

  // pin monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (sck && !sck_m) begin
      if (have_rise && (cyc - last_rise != exp_p)) bad_per = bad_per + 1;
      have_rise = 1'b1;
      last_rise = cyc;
    end
    if ((&cs_m) && !(&cs_n)) cs_falls = cs_falls + 1;
    if (!(&cs_m) && (&cs_n)) cs_rise_cyc = cyc;
    if (irq && !irq_m) irq_rise_cyc = cyc;
    if (irq) irq_seen = 1'b1;
    low_mask = low_mask | ~cs_n;
    sck_m = sck; cs_m = cs_n; irq_m = irq;
  end

  task automatic mon_clear(input int p);
    edges = 0; bitpos = 0; bad_per = 0; cs_falls = 0; last_rise = 0;
    cs_rise_cyc = 0; irq_rise_cyc = 0; have_rise = 1'b0; irq_seen = 1'b0;
    mosi_log = '0; low_mask = '0; exp_p = p;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk);
    reg_idx = i;
    #1 d = reg_rdata;
  endtask

  task automatic run_frame(input int presc, input int dsel, input int bank,
                           input int tx, input int rx, input logic [31:0] txword,
                           input int sd, input bit ie, input bit poke);
    int te, re, p, nb, polls;
    logic [31:0] rd, exp_rx;
    logic [63:0] sh;
    te = clampc(tx); re = clampc(rx);
    p  = (presc < 2) ? 2 : presc;
    nb = 8 * (te + re);
    bus_wr(3'd0, 32'h1000_000F | 32'(presc << 8) | 32'(dsel << 5));
    bus_wr(3'd3, txword);
    seed = sd;
    mon_clear(p);
    miso = resp_bit(0);
    bus_wr(3'd1, 32'(bank << 12) | (32'(ie) << 8) | 32'h80 | 32'(rx << 4) | 32'(tx));
    if (poke) begin
      repeat (6) @(negedge clk);
      bus_wr(3'd1, 32'(((bank + 1) % 4) << 12) | (32'(ie) << 8) | 32'h81);
    end
    polls = 0; rd = '0;
    while (!rd[8] && polls < 4000) begin
      bus_rd(3'd2, rd);
      polls = polls + 1;
    end
    check("R10 finished flag set after frame", 64'(rd[8]), 64'd1);
    check("R6 rising edge count", 64'(edges), 64'(nb));
    check("R6 SCK period violations", 64'(bad_per), 64'd0);
    check("R7 selected chip select mask", 64'(low_mask), 64'(1 << bank));
    check("R7 chip select fall count", 64'(cs_falls), 64'd1);
    for (int t = 0; t < te; t++) begin
      sh = mosi_log >> (nb - 8 - 8 * t);
      check("R4 transmitted byte", 64'(sh[7:0]), 64'(txword[8*t +: 8]));
    end
    bus_rd(3'd4, rd);
    exp_rx = '0;
    for (int k = 0; k < re; k++) exp_rx = exp_rx | (32'(resp_byte(te + k)) << (8 * k));
    check("R5 receive word", 64'(rd), 64'(exp_rx));
    if (ie) check("R12 deselect gap cycles", 64'(irq_rise_cyc - cs_rise_cyc), 64'(p * (dsel + 1)));
    else    check("R11 interrupt stays low when disabled", 64'(irq_seen), 64'd0);
    bus_wr(3'd2, 32'h0);
  endtask

  initial begin
    logic [31:0] rd;
    int plist [5];
    plist = '{1, 2, 3, 4, 6};
    rst_n = 1'b0; reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0; miso = 1'b0;
    sck_m = 1'b0; cs_m = 4'hF; irq_m = 1'b0;
    mon_clear(2);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      bus_rd(3'(i), rd);
      check("R1 register reset value", 64'(rd), 64'd0);
    end
    check("R1 chip selects high", 64'(cs_n), 64'hF);
    check("R1 sck low", 64'(sck), 64'd0);
    check("R1 irq low", 64'(irq), 64'd0);

    // R2 register layout
    bus_wr(3'd0, 32'hFFFF_FFFF);
    bus_rd(3'd0, rd); check("R2 mode word readback", 64'(rd), 64'h1000_0F6F);
    bus_wr(3'd1, 32'hFFFF_FF7F);
    bus_rd(3'd1, rd); check("R2 command word readback", 64'(rd), 64'h0000_3177);
    bus_wr(3'd3, 32'hDEAD_BEEF);
    bus_rd(3'd3, rd); check("R2 transmit word readback", 64'(rd), 64'hDEAD_BEEF);
    bus_wr(3'd4, 32'h1234_5678);
    bus_rd(3'd4, rd); check("R2 receive word ignores writes", 64'(rd), 64'd0);
    for (int i = 5; i < 8; i++) begin
      bus_rd(3'(i), rd); check("R2 unused index reads zero", 64'(rd), 64'd0);
    end
    bus_wr(3'd1, 32'h0);

    // R3 start without software mode
    bus_wr(3'd0, 32'h0000_020F);
    mon_clear(2);
    bus_wr(3'd1, 32'h0000_0192);
    repeat (100) @(negedge clk);
    bus_rd(3'd2, rd);
    check("R3 no finish without software mode", 64'(rd[8]), 64'd0);
    check("R3 no SCK without software mode", 64'(edges), 64'd0);
    check("R3 no chip select without software mode", 64'(cs_falls), 64'd0);

    // R9 disabled device and zero count
    bus_wr(3'd0, 32'h1000_020B);
    mon_clear(2);
    bus_wr(3'd1, 32'h0000_2082);
    bus_rd(3'd2, rd);
    check("R9 disabled device finishes at once", 64'(rd[8]), 64'd1);
    bus_wr(3'd2, 32'h0);
    bus_wr(3'd1, 32'h0000_0090);
    bus_rd(3'd2, rd);
    check("R9 zero transmit count finishes at once", 64'(rd[8]), 64'd1);
    repeat (50) @(negedge clk);
    check("R9 no SCK edges", 64'(edges), 64'd0);
    check("R9 no chip select activity", 64'(cs_falls), 64'd0);

    // R10 writing one keeps the flag, writing zero clears it
    bus_wr(3'd2, 32'h0000_0100);
    bus_rd(3'd2, rd); check("R10 write of one keeps flag", 64'(rd[8]), 64'd1);
    bus_wr(3'd2, 32'h0);
    bus_rd(3'd2, rd); check("R10 write of zero clears flag", 64'(rd[8]), 64'd0);

    // R4 R5 R6 R7 R12 sweep over prescaler and counts
    for (int pi = 0; pi < 5; pi++)
      for (int tx = 1; tx <= 4; tx++)
        for (int rx = 0; rx <= 4; rx++)
          run_frame(plist[pi], (tx + 2 * rx) % 4, (tx + rx) % 4, tx, rx,
                    32'hA55A_3CC3 ^ (32'(tx * 16 + rx) * 32'h0103_0507) ^ 32'(plist[pi]),
                    tx * 16 + rx + plist[pi], 1'b1, 1'b0);

    // R8 counts above four act as four
    run_frame(3, 1, 2, 7, 5, 32'h0102_039F, 91, 1'b1, 1'b0);
    run_frame(2, 0, 1, 5, 6, 32'hC0FF_EE11, 17, 1'b1, 1'b0);

    // R11 interrupt disabled
    run_frame(2, 2, 3, 1, 3, 32'h0000_009F, 5, 1'b0, 1'b0);

    // R12 start during a running frame is ignored
    run_frame(4, 3, 0, 4, 2, 32'h00AB_CDD8, 44, 1'b1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule